// File: doc/BRIEF.md
# Scanline prefetch and pixel unpacker for a doubled 2-bit display

This block drives a 640x480 display from a 320x240 image stored at 2 bits per pixel in a shared, byte-wide external SRAM. It never holds the whole frame on chip. Before each pair of display lines, it reads the 80 packed bytes of the next source line into an on-chip line buffer. Four pixels are packed in each byte.

The fetch runs in a short burst during horizontal blanking, so the SRAM bus stays free for the processor and other masters for the rest of the line. The buffer has two halves, used in ping-pong fashion. The display reads one half while the other half fills, so a slow grant cannot corrupt the line that is currently on screen.

On the display side, the block takes the horizontal and vertical counters of the timing generator. It returns one 2-bit pixel per clock. Each source pixel is repeated over two columns and over two rows.

The SRAM read port is a valid/ready stream:
- `sram_req` is the valid signal and `sram_gnt` is the ready signal.
- While `sram_req` is high without a grant, `sram_addr` holds its value.
- Only a granted cycle counts as a transfer.
- The byte read is presented on `sram_rdata` one clock after the granted cycle.

The pixel output has no back-pressure. It updates every clock.

Top module: `scanline_fetch`

## Requirements
- R1: After reset, `sram_req` is 0 and `pix` is 0.
- R2: A fetch of source line 0 starts when `hcount` equals 640 while `vcount` equals 524, which is the last line of the vertical blanking. `sram_req` rises on the next clock and the first address is `base_addr`.
- R3: Every fetch transfers exactly 80 granted bytes. `sram_req` falls on the clock after the 80th grant.
- R4: The byte with index i of source line s is read from address `base_addr + s*80 + i`. The index advances by one only on granted cycles.
- R5: The byte index of a display pixel is `hcount/8`. The slot within the byte is `(hcount/2) mod 4`. Slot 0 sits in bits [7:6], slot 1 in [5:4], slot 2 in [3:2] and slot 3 in [1:0]. As a result, every source pixel covers two adjacent columns.
- R6: Display lines 2k and 2k+1 show source line k.
- R7: When `hcount` >= 640 or `vcount` >= 480, `pix` is 0.
- R8: A fetch of source line k+1 is triggered when `hcount` equals 640 on display line 2k+1. This fetch does not change the pixels of source line k, which is still being displayed.
- R9: No fetch starts on an even display line, on display line 479, or when `hcount` differs from 640.
- R10: When the grant is withheld, the request and its address are held. The fetched line is still correct however the grants are spaced.
- R11: `pix` is registered. It shows the pixel for the counters sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 16 | SRAM byte address of source line 0 |
| hcount | input | 10 | Horizontal display counter |
| vcount | input | 10 | Vertical display counter |
| sram_req | output | 1 | Read request (valid) |
| sram_addr | output | 16 | Read byte address |
| sram_gnt | input | 1 | Read grant (ready) |
| sram_rdata | input | 8 | Read data, one clock after the grant |
| pix | output | 2 | Pixel value |

## Verification
The bench fetches a line while the arbiter grants only one cycle in three. During that fetch it scans the line on screen. A design without a separate fill half would show changed pixels there. A design that advanced the address without a grant would load shifted bytes.

Triggers on even lines and on line 479 are checked to confirm that they raise no request. A wrong line test would waste bus time or overwrite the displayed half.

Columns are probed at every slot of a byte and at both pixels of a doubled pair. Reversed bit order or missing doubling would show up as a mismatch there.

Blanking positions are also sampled. An unmasked output would leak buffer data into sync time.

// File: rtl/sfetch_pkg.sv
package sfetch_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/sfetch_ctrl.sv
module sfetch_ctrl
  import sfetch_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 10,
  parameter int IDX_W      = 7,
  parameter int LINE_BYTES = 80,
  parameter int DISP_W     = 640,
  parameter int DISP_H     = 480,
  parameter int V_TOTAL    = 525
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  hcount,
  input  logic [CNT_W-1:0]  vcount,
  input  logic              sram_gnt,
  output logic              sram_req,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [IDX_W-1:0]  wr_idx
);
  localparam logic [CNT_W-1:0] H_TRIG   = CNT_W'(DISP_W);
  localparam logic [CNT_W-1:0] V_LAST   = CNT_W'(V_TOTAL - 1);
  localparam logic [CNT_W-1:0] V_STOP   = CNT_W'(DISP_H - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_BYTES - 1);

  fetch_state_e     state_q;
  logic [CNT_W-1:0] line_q;
  logic [IDX_W-1:0] idx_q;
  logic             trig;
  logic [CNT_W-1:0] next_src;
  logic             xfer;

  always_comb begin
    trig = (hcount == H_TRIG) &&
           ((vcount == V_LAST) || (vcount[0] && (vcount < V_STOP)));
    if (vcount == V_LAST) next_src = '0;
    else                  next_src = CNT_W'(vcount + 1'b1) >> 1;
  end

  assign sram_req  = (state_q == FS_BUSY);
  assign xfer      = sram_req && sram_gnt;
  assign sram_addr = base_addr + ADDR_W'(line_q) * ADDR_W'(LINE_BYTES) + ADDR_W'(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      line_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (trig) begin
          state_q <= FS_BUSY;
          line_q  <= next_src;
          idx_q   <= '0;
        end
        FS_BUSY: if (sram_gnt) begin
          if (idx_q == LAST_IDX) state_q <= FS_IDLE;
          idx_q <= idx_q + 1'b1;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_bank <= 1'b0;
      wr_idx  <= '0;
    end else begin
      wr_en   <= xfer;
      wr_bank <= line_q[0];
      wr_idx  <= idx_q;
    end
  end
endmodule

// File: rtl/sfetch_linebuf.sv
module sfetch_linebuf #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic             wbank,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rbank,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_half
    logic [WIDTH-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b))) mem[waddr] <= wdata;
    end
    assign bank_q[b] = mem[raddr];
  end

  assign rdata = bank_q[rbank];
endmodule

// File: rtl/sfetch_unpack.sv
module sfetch_unpack #(
  parameter int CNT_W  = 10,
  parameter int IDX_W  = 7,
  parameter int BPP    = 2,
  parameter int DISP_W = 640,
  parameter int DISP_H = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hcount,
  input  logic [CNT_W-1:0] vcount,
  input  logic [7:0]       rd_byte,
  output logic             rd_bank,
  output logic [IDX_W-1:0] rd_idx,
  output logic [BPP-1:0]   pix
);
  localparam int PPB    = 8 / BPP;
  localparam int SLOT_W = $clog2(PPB);

  logic [SLOT_W-1:0] slot;
  logic [3:0]        shamt;
  logic [7:0]        shifted;
  logic              active;

  assign rd_idx  = hcount[1+SLOT_W +: IDX_W];
  assign rd_bank = vcount[1];
  assign slot    = hcount[SLOT_W:1];
  assign active  = (hcount < CNT_W'(DISP_W)) && (vcount < CNT_W'(DISP_H));

  always_comb begin
    shamt   = 4'((PPB - 1 - int'(slot)) * BPP);
    shifted = rd_byte >> shamt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pix <= '0;
    else if (active) pix <= shifted[BPP-1:0];
    else             pix <= '0;
  end
endmodule

// File: rtl/scanline_fetch.sv
module scanline_fetch #(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 10,
  parameter int BPP     = 2,
  parameter int DISP_W  = 640,
  parameter int DISP_H  = 480,
  parameter int V_TOTAL = 525
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  hcount,
  input  logic [CNT_W-1:0]  vcount,
  output logic              sram_req,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic              sram_gnt,
  input  logic [7:0]        sram_rdata,
  output logic [BPP-1:0]    pix
);
  localparam int SRC_W      = DISP_W / 2;
  localparam int LINE_BYTES = SRC_W * BPP / 8;
  localparam int IDX_W      = $clog2(LINE_BYTES);

  logic             wr_en;
  logic             wr_bank;
  logic [IDX_W-1:0] wr_idx;
  logic             rd_bank;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;

  sfetch_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES),
    .DISP_W(DISP_W), .DISP_H(DISP_H), .V_TOTAL(V_TOTAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .hcount(hcount), .vcount(vcount), .sram_gnt(sram_gnt),
    .sram_req(sram_req), .sram_addr(sram_addr),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx)
  );

  sfetch_linebuf #(.WIDTH(8), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_idx), .wdata(sram_rdata),
    .rbank(rd_bank), .raddr(rd_idx), .rdata(rd_byte)
  );

  sfetch_unpack #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .BPP(BPP), .DISP_W(DISP_W), .DISP_H(DISP_H)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .rd_byte(rd_byte), .rd_bank(rd_bank), .rd_idx(rd_idx), .pix(pix)
  );
endmodule

// File: rtl/sfetch_chk.sv
module sfetch_chk #(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 10,
  parameter int BPP     = 2,
  parameter int DISP_W  = 640,
  parameter int DISP_H  = 480,
  parameter int V_TOTAL = 525
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  hcount,
  input logic [CNT_W-1:0]  vcount,
  input logic              sram_req,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_gnt,
  input logic [BPP-1:0]    pix
);
  localparam int LINE_BYTES = (DISP_W / 2) * BPP / 8;

  logic [7:0] burst_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !sram_req) burst_cnt <= '0;
    else if (sram_gnt)       burst_cnt <= burst_cnt + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && !sram_gnt) |=> (sram_req && $stable(sram_addr))); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && sram_gnt) |=> (!sram_req || (sram_addr == $past(sram_addr) + 1'b1))); // R4

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_req) |-> (burst_cnt == 8'(LINE_BYTES))); // R3

  AST_START_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_req) |-> (($past(hcount) == CNT_W'(DISP_W)) &&
      (($past(vcount) == CNT_W'(V_TOTAL - 1)) ||
       ($past(vcount[0]) && ($past(vcount) < CNT_W'(DISP_H - 1)))))); // R9

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((hcount >= CNT_W'(DISP_W)) || (vcount >= CNT_W'(DISP_H))) |=> (pix == '0)); // R7
endmodule

bind scanline_fetch sfetch_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BPP(BPP),
  .DISP_W(DISP_W), .DISP_H(DISP_H), .V_TOTAL(V_TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
  .sram_req(sram_req), .sram_addr(sram_addr), .sram_gnt(sram_gnt), .pix(pix)
);

// File: tb/tb_scanline_fetch.sv
module tb_scanline_fetch;
  localparam int BASE = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_addr = 16'(BASE);
  logic [9:0]  hcount = '0;
  logic [9:0]  vcount = '0;
  logic        sram_req;
  logic [15:0] sram_addr;
  logic        sram_gnt;
  logic [7:0]  sram_rdata = '0;
  logic [1:0]  pix;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit stall_mode = 0;
  int exp_line = 0, grant_cnt = 0, addr_err = 0, req_cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scanline_fetch dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .hcount(hcount), .vcount(vcount),
    .sram_req(sram_req), .sram_addr(sram_addr), .sram_gnt(sram_gnt),
    .sram_rdata(sram_rdata), .pix(pix)
  );

  function automatic logic [7:0] mdata(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic int ref_pix(int h, int v);
    int a, s;
    if (h >= 640 || v >= 480) return 0;
    a = BASE + (v / 2) * 80 + h / 8;
    s = (h / 2) % 4;
    return (int'(mdata(a)) >> (6 - 2 * s)) & 3;
  endfunction

  assign sram_gnt = stall_mode ? (cyc % 3 == 0) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sram_req && sram_gnt) sram_rdata <= mdata(int'(sram_addr));
    if (rst_n && sram_req) begin
      req_cycles++;
      if (sram_gnt) begin
        if (int'(sram_addr) != BASE + exp_line * 80 + grant_cnt) addr_err++;
        grant_cnt++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic show(int h, int v, output int got);
    @(negedge clk);
    hcount = 10'(h); vcount = 10'(v);
    @(negedge clk);
    got = int'(pix);
  endtask

  task automatic fetch(int trig_v, int line, bit scan, output int scan_err);
    int prev_h = -1;
    scan_err = 0;
    exp_line = line; grant_cnt = 0; addr_err = 0; req_cycles = 0;
    @(negedge clk);
    hcount = 10'd640; vcount = 10'(trig_v);
    @(negedge clk);
    hcount = 10'd700;
    for (int k = 0; k < 2000; k++) begin
      if (grant_cnt >= 80 && !sram_req) break;
      if (scan) begin
        if (prev_h >= 0 && int'(pix) != ref_pix(prev_h, 1)) scan_err++;
        prev_h = (prev_h < 0) ? 3 : (prev_h + 7) % 640;
        hcount = 10'(prev_h); vcount = 10'd1;
      end
      @(negedge clk);
    end
    hcount = 10'd700;
    repeat (2) @(negedge clk);
  endtask

  localparam int NV = 12;
  localparam logic [19:0] VECS [NV] = '{
    {10'd0, 10'd0},   {10'd1, 10'd0},   {10'd2, 10'd0},   {10'd3, 10'd0},
    {10'd6, 10'd0},   {10'd9, 10'd1},   {10'd15, 10'd1},  {10'd321, 10'd0},
    {10'd639, 10'd1}, {10'd640, 10'd0}, {10'd799, 10'd0}, {10'd10, 10'd480}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int got, got2, serr;
    repeat (3) @(negedge clk);
    check(sram_req == 1'b0, "R1 req", int'(sram_req), 0);
    check(pix == 2'd0, "R1 pix", int'(pix), 0);
    rst_n = 1'b1;

    // R9: no fetch on even line, line 479, or off-slot column
    @(negedge clk); hcount = 10'd640; vcount = 10'd2;
    @(negedge clk); hcount = 10'd640; vcount = 10'd479;
    @(negedge clk); hcount = 10'd639; vcount = 10'd524;
    @(negedge clk); hcount = 10'd700;
    @(negedge clk);
    check(req_cycles == 0, "R9 no request", req_cycles, 0);

    // R2, R3, R4: fetch line 0 from vertical blanking
    fetch(524, 0, 0, serr);
    check(grant_cnt == 80, "R3 grant count", grant_cnt, 80);
    check(addr_err == 0, "R2 R4 address sequence", addr_err, 0);
    check(sram_req == 1'b0, "R3 req dropped", int'(sram_req), 0);

    // R5, R7, R11: table walk
    for (int i = 0; i < NV; i++) begin
      int h = int'(VECS[i][19:10]);
      int v = int'(VECS[i][9:0]);
      show(h, v, got);
      check(got == ref_pix(h, v), (h >= 640 || v >= 480) ? "R7 blank" : "R5 R11 unpack",
            got, ref_pix(h, v));
    end

    // R6: both display lines of a pair match
    for (int h = 0; h < 640; h += 53) begin
      show(h, 0, got); show(h, 1, got2);
      check(got == got2 && got == ref_pix(h, 0), "R6 line pair", got2, ref_pix(h, 0));
    end

    // R8, R10: slow grants while scanning the displayed line
    stall_mode = 1;
    fetch(1, 1, 1, serr);
    stall_mode = 0;
    check(serr == 0, "R8 displayed half untouched", serr, 0);
    check(addr_err == 0 && grant_cnt == 80, "R10 stalled fetch addresses", addr_err, 0);
    check(req_cycles > 200, "R10 request held through stalls", req_cycles, 240);
    serr = 0;
    for (int h = 1; h < 640; h += 29) begin
      show(h, 2, got); if (got != ref_pix(h, 2)) serr++;
      show(h, 3, got); if (got != ref_pix(h, 3)) serr++;
    end
    check(serr == 0, "R10 R6 stalled line data", serr, 0);

    // R4, R8: line 2 into the other half
    fetch(3, 2, 0, serr);
    check(addr_err == 0, "R4 line 2 addresses", addr_err, 0);
    show(37, 4, got);
    check(got == ref_pix(37, 4), "R5 line 2 pixel", got, ref_pix(37, 4));
    show(37, 2, got);
    check(got == ref_pix(37, 2), "R8 line 1 half intact", got, ref_pix(37, 2));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule